// File: doc/BRIEF.md
# Two-Beat Wide Ternary Search Core

This block holds a ternary match table of wide entries. Each entry is a pair of 72-bit words: the word at the even address holds the upper half and the word at the odd address holds the lower half. Each stored word has its own local mask. A search key of 144 bits reaches the block as two consecutive 72-bit beats on one data bus. The first beat carries the upper half, the index of a global mask pair and three upper address bits. The second beat carries the lower half, the index of a comparand slot and the index of a result slot.

The core applies the selected global mask and the per-word local masks. It compares the key against every stored pair in parallel and picks the lowest matching pair. A fixed number of command slots after the first beat, it returns a hit flag and a 24-bit address. The full key is kept in the chosen comparand slot and the outcome in the chosen result slot. Both can be read through registered peek ports.

A minimal fill port loads table words and global mask words. Searches run at one per two clock cycles.

Top module: `ternary_search_core`

## Requirements
- R1: After synchronous reset, `rsp_valid` is 0, every result slot reads back as all zero on `peek_rslt`, and every table word is empty, so any search misses.
- R2: A search starts only when two consecutive cycles both have `cmd_valid`=1 and `cmd_code`=2'b10, and the first of them has `cmd_mode`=0. A first beat with `cmd_mode`=1 is ignored. A first beat followed by any other cycle is dropped without a response.
- R3: A pair matches only if both of its words are loaded. The first-beat data must match the even word of the pair, and the second-beat data must match the odd word.
- R4: A key bit is ignored when the word's local mask bit is 1 or the global mask bit is 1. The global mask pair comes from `cmd_gm_sel` on the first beat: its even word (`gm_word[0]`=0) masks the upper half and its odd word (`gm_word[0]`=1) masks the lower half.
- R5: When several pairs match, the pair with the lowest index wins. A hit address therefore always ends in bit 0 = 0.
- R6: `rsp_valid` is high for exactly one cycle, after the 2*LAT_SLOTS-th rising edge counted from the edge that samples the first beat. Back-to-back searches are accepted every two cycles.
- R7: On a hit, `rsp_addr` equals {`cmd_hi` of the first beat, zeros, pair index, 1'b0}. The pair index sits directly above bit 0.
- R8: On a miss, `rsp_hit`=0 and `rsp_addr`=0. Outside a response, both are 0.
- R9: The second beat stores {first-beat data, second-beat data} into comparand slot `cmd_cmp_sel`. `peek_cmp` shows slot `peek_cmp_sel` one cycle after selection.
- R10: The slot named by `cmd_rslt_sel` on the second beat is updated one cycle after the response. On a hit it takes {1, address}. On a miss its flag is cleared and its address is kept. `peek_rslt` = {flag, address} of slot `peek_rslt_sel`, one cycle late.
- R11: `ld_en` writes `ld_data` and `ld_mask` into table word `ld_word` and marks that word loaded. `gm_en` writes `gm_data` into global mask word `gm_word` (bits [4:1] give the pair, bit 0 gives the half).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command beat valid |
| cmd_code | input | 2 | Command code, 2'b10 = search |
| cmd_mode | input | 1 | First-beat mode bit, must be 0 |
| cmd_gm_sel | input | 4 | First beat: global mask pair index |
| cmd_hi | input | 3 | First beat: upper address bits returned on hit |
| cmd_cmp_sel | input | 4 | Second beat: comparand slot index |
| cmd_rslt_sel | input | 3 | Second beat: result slot index |
| key_bus | input | 72 | Key half: upper on first beat, lower on second |
| ld_en | input | 1 | Table word write enable |
| ld_word | input | 5 | Table word address |
| ld_data | input | 72 | Table word data |
| ld_mask | input | 72 | Table word local mask, 1 = ignore bit |
| gm_en | input | 1 | Global mask write enable |
| gm_word | input | 5 | Global mask word: [4:1] pair, [0] half |
| gm_data | input | 72 | Global mask data, 1 = ignore bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Response hit flag |
| rsp_addr | output | 24 | Response address |
| peek_rslt_sel | input | 3 | Result slot to read |
| peek_rslt | output | 25 | {flag, address} of selected result slot |
| peek_cmp_sel | input | 4 | Comparand slot to read |
| peek_cmp | output | 144 | Selected comparand slot |

## Verification
The bench fills the table with words drawn from a small alphabet and with sparse random masks, so that most searches see several matching pairs. A priority encoder that picked the highest index, or one that merged hits across pairs, would then return the wrong address. Directed keys match only one half of a pair; a core that matched the halves separately, or swapped them, would report hits where a miss is expected. Broken command framing is checked cycle by cycle against an expected-response queue: mode-1 first beats, first beats followed by idle, and wrong second-beat codes. A core that started on a single beat, or that was off by one command slot, would raise a stray or late `rsp_valid`. Result slots are read back after misses, which exposes an address that was overwritten when it should have been kept.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned HALF_W = 72;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned HI_W   = 3;
  localparam logic [1:0]  CODE_SEARCH = 2'b10;
endpackage

// File: rtl/tsc_cmd_capture.sv
module tsc_cmd_capture #(
  parameter int unsigned HALF_W   = 72,
  parameter int unsigned HI_W     = 3,
  parameter int unsigned GM_SEL_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_code,
  input  logic                cmd_mode,
  input  logic [GM_SEL_W-1:0] cmd_gm_sel,
  input  logic [HI_W-1:0]     cmd_hi,
  input  logic [HALF_W-1:0]   key_bus,
  output logic                a_fire,
  output logic                b_fire,
  output logic [HALF_W-1:0]   key_hi_q,
  output logic [HI_W-1:0]     hi_q,
  output logic [GM_SEL_W-1:0] gm_sel_q
);
  import tsc_pkg::*;

  logic have_a;
  logic is_srch;

  assign is_srch = cmd_valid && (cmd_code == CODE_SEARCH);
  assign a_fire  = !have_a && is_srch && !cmd_mode;
  assign b_fire  = have_a && is_srch;

  // a first beat is held for exactly one cycle; anything but a second beat drops it
  always_ff @(posedge clk) begin
    if (rst) have_a <= 1'b0;
    else     have_a <= a_fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_hi_q <= '0;
      hi_q     <= '0;
      gm_sel_q <= '0;
    end else if (a_fire) begin
      key_hi_q <= key_bus;
      hi_q     <= cmd_hi;
      gm_sel_q <= cmd_gm_sel;
    end
  end
endmodule

// File: rtl/tsc_match_array.sv
module tsc_match_array #(
  parameter int unsigned PAIRS   = 16,
  parameter int unsigned HALF_W  = 72,
  parameter int unsigned WADDR_W = $clog2(2*PAIRS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic [WADDR_W-1:0] ld_word,
  input  logic [HALF_W-1:0]  ld_data,
  input  logic [HALF_W-1:0]  ld_mask,
  input  logic [HALF_W-1:0]  key_hi,
  input  logic [HALF_W-1:0]  key_lo,
  input  logic [HALF_W-1:0]  gm_hi,
  input  logic [HALF_W-1:0]  gm_lo,
  output logic [PAIRS-1:0]   match
);
  localparam int unsigned WORDS = 2*PAIRS;

  logic [HALF_W-1:0] ent_d [WORDS];
  logic [HALF_W-1:0] ent_m [WORDS];
  logic [WORDS-1:0]  ent_v;

  always_ff @(posedge clk) begin
    if (ld_en) begin
      ent_d[ld_word] <= ld_data;
      ent_m[ld_word] <= ld_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        ent_v <= '0;
    else if (ld_en) ent_v[ld_word] <= 1'b1;
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic hi_ok, lo_ok;
    assign hi_ok = ~|((key_hi ^ ent_d[2*p])   & ~ent_m[2*p]   & ~gm_hi);
    assign lo_ok = ~|((key_lo ^ ent_d[2*p+1]) & ~ent_m[2*p+1] & ~gm_lo);
    assign match[p] = ent_v[2*p] && ent_v[2*p+1] && hi_ok && lo_ok;
  end
endmodule

// File: rtl/tsc_prio_enc.sv
module tsc_prio_enc #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ternary_search_core.sv
module ternary_search_core #(
  parameter int unsigned PAIRS     = 16,
  parameter int unsigned GM_SEL_W  = 4,
  parameter int unsigned CMP_SEL_W = 4,
  parameter int unsigned RS_SEL_W  = 3,
  parameter int unsigned LAT_SLOTS = 5,
  parameter int unsigned WADDR_W   = $clog2(2*PAIRS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cmd_valid,
  input  logic [1:0]                     cmd_code,
  input  logic                           cmd_mode,
  input  logic [GM_SEL_W-1:0]            cmd_gm_sel,
  input  logic [tsc_pkg::HI_W-1:0]       cmd_hi,
  input  logic [CMP_SEL_W-1:0]           cmd_cmp_sel,
  input  logic [RS_SEL_W-1:0]            cmd_rslt_sel,
  input  logic [tsc_pkg::HALF_W-1:0]     key_bus,
  input  logic                           ld_en,
  input  logic [WADDR_W-1:0]             ld_word,
  input  logic [tsc_pkg::HALF_W-1:0]     ld_data,
  input  logic [tsc_pkg::HALF_W-1:0]     ld_mask,
  input  logic                           gm_en,
  input  logic [GM_SEL_W:0]              gm_word,
  input  logic [tsc_pkg::HALF_W-1:0]     gm_data,
  output logic                           rsp_valid,
  output logic                           rsp_hit,
  output logic [tsc_pkg::ADDR_W-1:0]     rsp_addr,
  input  logic [RS_SEL_W-1:0]            peek_rslt_sel,
  output logic [tsc_pkg::ADDR_W:0]       peek_rslt,
  input  logic [CMP_SEL_W-1:0]           peek_cmp_sel,
  output logic [2*tsc_pkg::HALF_W-1:0]   peek_cmp
);
  import tsc_pkg::*;

  localparam int unsigned GM_PAIRS  = 1 << GM_SEL_W;
  localparam int unsigned CMP_SLOTS = 1 << CMP_SEL_W;
  localparam int unsigned RS_SLOTS  = 1 << RS_SEL_W;
  localparam int unsigned PIDX_W    = WADDR_W - 1;
  localparam int unsigned DLY       = 2*LAT_SLOTS - 2;

  // ---------------- command framing
  logic                a_fire, b_fire;
  logic [HALF_W-1:0]   key_hi_q;
  logic [HI_W-1:0]     hi_q;
  logic [GM_SEL_W-1:0] gm_sel_q;

  tsc_cmd_capture #(.HALF_W(HALF_W), .HI_W(HI_W), .GM_SEL_W(GM_SEL_W)) u_cap (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_mode(cmd_mode), .cmd_gm_sel(cmd_gm_sel), .cmd_hi(cmd_hi),
    .key_bus(key_bus), .a_fire(a_fire), .b_fire(b_fire),
    .key_hi_q(key_hi_q), .hi_q(hi_q), .gm_sel_q(gm_sel_q)
  );

  // ---------------- global mask memories, registered read on the first beat
  logic [HALF_W-1:0] gm_even [GM_PAIRS];
  logic [HALF_W-1:0] gm_odd  [GM_PAIRS];
  logic [HALF_W-1:0] gm_rd_hi, gm_rd_lo;

  always_ff @(posedge clk) begin
    if (gm_en && !gm_word[0]) gm_even[gm_word[GM_SEL_W:1]] <= gm_data;
    if (a_fire)               gm_rd_hi <= gm_even[cmd_gm_sel];
  end

  always_ff @(posedge clk) begin
    if (gm_en && gm_word[0]) gm_odd[gm_word[GM_SEL_W:1]] <= gm_data;
    if (a_fire)              gm_rd_lo <= gm_odd[cmd_gm_sel];
  end

  // ---------------- comparand memory
  logic [2*HALF_W-1:0] cmp_mem [CMP_SLOTS];

  always_ff @(posedge clk) begin
    if (b_fire) cmp_mem[cmd_cmp_sel] <= {key_hi_q, key_bus};
    peek_cmp <= cmp_mem[peek_cmp_sel];
  end

  // ---------------- stage 1: full key assembled
  logic                s1_v;
  logic [HALF_W-1:0]   s1_khi, s1_klo;
  logic [HI_W-1:0]     s1_hi;
  logic [RS_SEL_W-1:0] s1_rs;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_khi <= '0; s1_klo <= '0; s1_hi <= '0; s1_rs <= '0;
    end else begin
      s1_v <= b_fire;
      if (b_fire) begin
        s1_khi <= key_hi_q;
        s1_klo <= key_bus;
        s1_hi  <= hi_q;
        s1_rs  <= cmd_rslt_sel;
      end
    end
  end

  // ---------------- stage 2: match vector
  logic [PAIRS-1:0]    match_c, s2_match;
  logic                s2_v;
  logic [HI_W-1:0]     s2_hi;
  logic [RS_SEL_W-1:0] s2_rs;

  tsc_match_array #(.PAIRS(PAIRS), .HALF_W(HALF_W), .WADDR_W(WADDR_W)) u_arr (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_word(ld_word),
    .ld_data(ld_data), .ld_mask(ld_mask),
    .key_hi(s1_khi), .key_lo(s1_klo), .gm_hi(gm_rd_hi), .gm_lo(gm_rd_lo),
    .match(match_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0; s2_match <= '0; s2_hi <= '0; s2_rs <= '0;
    end else begin
      s2_v     <= s1_v;
      s2_match <= s1_v ? match_c : '0;
      s2_hi    <= s1_hi;
      s2_rs    <= s1_rs;
    end
  end

  // ---------------- priority encode and address forming
  logic              win_found;
  logic [PIDX_W-1:0] win_idx;
  logic [ADDR_W-1:0] win_addr;

  tsc_prio_enc #(.N(PAIRS), .IW(PIDX_W)) u_pe (
    .vec(s2_match), .found(win_found), .idx(win_idx)
  );

  always_comb begin
    win_addr = '0;
    if (s2_v && win_found) begin
      win_addr[ADDR_W-1 -: HI_W] = s2_hi;
      win_addr[WADDR_W-1:1]      = win_idx;
    end
  end

  // ---------------- fixed delay line to the response slot
  logic                p_v    [DLY];
  logic                p_hit  [DLY];
  logic [ADDR_W-1:0]   p_addr [DLY];
  logic [RS_SEL_W-1:0] p_rs   [DLY];

  always_ff @(posedge clk) begin
    if (rst) begin
      p_v[0] <= 1'b0; p_hit[0] <= 1'b0; p_addr[0] <= '0; p_rs[0] <= '0;
    end else begin
      p_v[0]    <= s2_v;
      p_hit[0]  <= s2_v && win_found;
      p_addr[0] <= win_addr;
      p_rs[0]   <= s2_rs;
    end
  end

  for (genvar k = 1; k < DLY; k++) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) begin
        p_v[k] <= 1'b0; p_hit[k] <= 1'b0; p_addr[k] <= '0; p_rs[k] <= '0;
      end else begin
        p_v[k]    <= p_v[k-1];
        p_hit[k]  <= p_hit[k-1];
        p_addr[k] <= p_addr[k-1];
        p_rs[k]   <= p_rs[k-1];
      end
    end
  end

  assign rsp_valid = p_v[DLY-1];
  assign rsp_hit   = p_hit[DLY-1];
  assign rsp_addr  = p_addr[DLY-1];

  // ---------------- result slots
  logic              rs_hit  [RS_SLOTS];
  logic [ADDR_W-1:0] rs_addr [RS_SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RS_SLOTS; i++) begin
        rs_hit[i]  <= 1'b0;
        rs_addr[i] <= '0;
      end
      peek_rslt <= '0;
    end else begin
      if (rsp_valid) begin
        rs_hit[p_rs[DLY-1]] <= rsp_hit;
        if (rsp_hit) rs_addr[p_rs[DLY-1]] <= rsp_addr;
      end
      peek_rslt <= {rs_hit[peek_rslt_sel], rs_addr[peek_rslt_sel]};
    end
  end
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int unsigned LAT_SLOTS = 5,
  parameter int unsigned ADDR_W    = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [ADDR_W-1:0] rsp_addr
);
  localparam int unsigned LIM = 2*LAT_SLOTS + 1;
  localparam int unsigned CW  = $clog2(LIM + 1);

  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                      since_rst <= '0;
    else if (since_rst < CW'(LIM)) since_rst <= since_rst + 1'b1;
  end

  // R6: no response can exist before a full pipeline has elapsed
  p_quiet_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CW'(LIM)) |-> !rsp_valid);

  // R6: searches are one per two cycles, so responses never touch
  p_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8: miss carries a zero address
  p_miss_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0));

  // R8: outputs idle between responses
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && rsp_addr == '0));

  // R5: wide hits land on an even address
  p_even_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> !rsp_addr[0]);
endmodule

bind ternary_search_core tsc_checker #(.LAT_SLOTS(LAT_SLOTS), .ADDR_W(tsc_pkg::ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr)
);

// File: tb/ternary_search_core_bench.sv
module ternary_search_core_bench;
  localparam int LAT = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 0;
  logic [1:0]   cmd_code = 0;
  logic         cmd_mode = 0;
  logic [3:0]   cmd_gm_sel = 0;
  logic [2:0]   cmd_hi = 0;
  logic [3:0]   cmd_cmp_sel = 0;
  logic [2:0]   cmd_rslt_sel = 0;
  logic [71:0]  key_bus = 0;
  logic         ld_en = 0;
  logic [4:0]   ld_word = 0;
  logic [71:0]  ld_data = 0, ld_mask = 0;
  logic         gm_en = 0;
  logic [4:0]   gm_word = 0;
  logic [71:0]  gm_data = 0;
  logic         rsp_valid, rsp_hit;
  logic [23:0]  rsp_addr;
  logic [2:0]   peek_rslt_sel = 0;
  logic [24:0]  peek_rslt;
  logic [3:0]   peek_cmp_sel = 0;
  logic [143:0] peek_cmp;

  always #5 clk = ~clk;

  ternary_search_core u_ternary_search_core (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_mode(cmd_mode), .cmd_gm_sel(cmd_gm_sel), .cmd_hi(cmd_hi),
    .cmd_cmp_sel(cmd_cmp_sel), .cmd_rslt_sel(cmd_rslt_sel), .key_bus(key_bus),
    .ld_en(ld_en), .ld_word(ld_word), .ld_data(ld_data), .ld_mask(ld_mask),
    .gm_en(gm_en), .gm_word(gm_word), .gm_data(gm_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
    .peek_rslt_sel(peek_rslt_sel), .peek_rslt(peek_rslt),
    .peek_cmp_sel(peek_cmp_sel), .peek_cmp(peek_cmp)
  );

  // ---------------- behavioural model state
  logic [71:0]  m_d [32];
  logic [71:0]  m_m [32];
  bit           m_v [32];
  logic [71:0]  m_gm [16][2];
  logic [143:0] m_cmp [16];
  logic [24:0]  m_rs [8];

  typedef struct { int due; bit hit; logic [23:0] addr; int rs; } exp_t;
  exp_t q[$];

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit mon_on = 0;
  int pend_due;
  logic [71:0] pend_hi;
  logic [3:0]  pend_gm;
  logic [2:0]  pend_top;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [143:0] act, logic [143:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the expected-response queue
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk("R6 response strobe", 144'(rsp_valid), 144'(1));
        chk("R3 R4 R5 hit flag", 144'(rsp_hit), 144'(e.hit));
        chk("R5 R7 R8 address", 144'(rsp_addr), 144'(e.addr));
        m_rs[e.rs][24] = e.hit;
        if (e.hit) m_rs[e.rs][23:0] = e.addr;
      end else begin
        chk("R2 R6 no stray response", 144'(rsp_valid), 144'(0));
      end
    end
  end

  function automatic void model_search(input logic [71:0] khi, input logic [71:0] klo,
      input logic [3:0] g, input logic [2:0] top, output bit hit, output logic [23:0] addr);
    hit = 0; addr = '0;
    for (int p = 0; p < 16; p++) begin
      bit ok;
      ok = m_v[2*p] && m_v[2*p+1]
        && (((khi ^ m_d[2*p])   & ~m_m[2*p]   & ~m_gm[g][0]) == '0)
        && (((klo ^ m_d[2*p+1]) & ~m_m[2*p+1] & ~m_gm[g][1]) == '0);
      if (ok && !hit) begin
        hit = 1;
        addr = {top, 16'h0, p[3:0], 1'b0};
      end
    end
  endfunction

  task automatic idle();
    @(negedge clk);
    cmd_valid = 0; cmd_code = 0; cmd_mode = 0; ld_en = 0; gm_en = 0;
  endtask

  task automatic load_word(int w, logic [71:0] d, logic [71:0] m);
    @(negedge clk);
    cmd_valid = 0; gm_en = 0;
    ld_en = 1; ld_word = 5'(w); ld_data = d; ld_mask = m;
    m_d[w] = d; m_m[w] = m; m_v[w] = 1;
  endtask

  task automatic load_gm(int g, int half, logic [71:0] d);
    @(negedge clk);
    cmd_valid = 0; ld_en = 0;
    gm_en = 1; gm_word = {4'(g), 1'(half)}; gm_data = d;
    m_gm[g][half] = d;
  endtask

  task automatic beat_a(logic [71:0] khi, logic [3:0] g, logic [2:0] top, bit mode);
    @(negedge clk);
    ld_en = 0; gm_en = 0;
    cmd_valid = 1; cmd_code = 2'b10; cmd_mode = mode;
    cmd_gm_sel = g; cmd_hi = top; key_bus = khi;
    pend_due = cyc + 2*LAT + 1; pend_hi = khi; pend_gm = g; pend_top = top;
  endtask

  task automatic beat_b(logic [71:0] klo, logic [3:0] c, logic [2:0] r);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1; cmd_code = 2'b10; cmd_mode = 0;
    cmd_cmp_sel = c; cmd_rslt_sel = r; key_bus = klo;
    e.due = pend_due; e.rs = int'(r);
    model_search(pend_hi, klo, pend_gm, pend_top, e.hit, e.addr);
    q.push_back(e);
    m_cmp[c] = {pend_hi, klo};
  endtask

  task automatic search(logic [71:0] khi, logic [71:0] klo, logic [3:0] g,
                        logic [2:0] top, logic [3:0] c, logic [2:0] r);
    beat_a(khi, g, top, 0);
    beat_b(klo, c, r);
  endtask

  task automatic drain();
    for (int i = 0; i < 2*LAT + 4; i++) idle();
  endtask

  task automatic peek_all_rs(string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); peek_rslt_sel = 3'(i);
      @(negedge clk); chk(tag, 144'(peek_rslt), 144'(m_rs[i]));
    end
  endtask

  function automatic logic [71:0] alpha(int k);
    return {8{9'(k*37 + 5)}};
  endfunction

  localparam logic [71:0] KA = 72'h12_3456_789A_BCDE_F012;
  localparam logic [71:0] KB = 72'hFE_DCBA_9876_5432_10AB;
  localparam logic [71:0] KC = 72'h0F_0F0F_0F0F_0F0F_0F0F;
  localparam logic [71:0] KD = 72'hA5_A5A5_A5A5_A5A5_A5A5;

  initial begin
    for (int i = 0; i < 32; i++) begin m_v[i] = 0; m_d[i] = '0; m_m[i] = '0; end
    for (int i = 0; i < 8; i++)  m_rs[i] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    mon_on = 1;
    // R1: reset state
    chk("R1 reset strobe", 144'(rsp_valid), 144'(0));
    peek_all_rs("R1 result slots after reset");
    for (int g = 0; g < 16; g++) begin load_gm(g, 0, '0); load_gm(g, 1, '0); end
    idle();
    // R1: empty table misses
    search(KA, KB, 0, 3'b101, 0, 0);
    drain();

    // R11 R5 R7: two identical pairs, lowest wins
    load_word(6, KA, '0);  load_word(7, KB, '0);
    load_word(10, KA, '0); load_word(11, KB, '0);
    // R4: local mask on low byte of even word of pair 7
    load_word(14, KC, 72'hFF); load_word(15, KD, '0);
    load_gm(2, 1, '1);
    idle();
    search(KA, KB, 0, 3'b101, 1, 2);         // hit pair 3
    search(KA, ~KB, 0, 3'b011, 2, 3);        // R3 odd half differs: miss
    search(~KA, KB, 0, 3'b011, 3, 4);        // R3 even half differs: miss
    search(KB, KA, 0, 3'b001, 4, 5);         // R3 swapped halves: miss
    search(KC ^ 72'h5A, KD, 0, 3'b110, 5, 6); // R4 local mask: hit pair 7
    search(KC ^ 72'h100, KD, 0, 3'b110, 6, 7); // R4 outside local mask: miss
    search(KA, 72'h0, 2, 3'b111, 7, 2);      // R4 global mask ignores lower half
    search(KA, 72'h0, 1, 3'b111, 8, 2);      // R4 other mask pair: miss, R10 keeps address
    drain();
    peek_all_rs("R10 result slots directed");

    // R2: broken framing gives no response
    beat_a(KA, 0, 0, 1); idle();             // mode bit set
    beat_a(KA, 0, 0, 0); idle();             // lone first beat
    beat_a(KA, 0, 0, 0);
    @(negedge clk); cmd_valid = 1; cmd_code = 2'b01; key_bus = KB;
    idle();
    beat_a(KA, 0, 0, 0);
    @(negedge clk); cmd_valid = 0; cmd_code = 2'b10; key_bus = KB;
    drain();

    // randomized table with heavy overlap
    for (int w = 0; w < 32; w++)
      load_word(w, alpha($urandom_range(0, 3)),
                (($urandom_range(0, 3) == 0) ? {8'h0, 64'hFF00_0000_0000_00FF} : 72'h0));
    load_gm(1, 0, {$urandom, $urandom, 8'h0} & {$urandom, $urandom, 8'h0});
    load_gm(3, 1, {8'h0, $urandom, $urandom} & {8'h0, $urandom, $urandom});
    idle();
    for (int n = 0; n < 300; n++) begin
      search(alpha($urandom_range(0, 3)), alpha($urandom_range(0, 3)),
             4'($urandom_range(0, 3)), 3'($urandom), 4'($urandom), 3'($urandom));
      if ($urandom_range(0, 7) == 0) begin beat_a(KA, 0, 0, 1); idle(); end
      if ($urandom_range(0, 7) == 0) idle();
    end
    drain();
    peek_all_rs("R10 result slots random");
    // R9: comparand slots
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); peek_cmp_sel = 4'(i);
      @(negedge clk); chk("R9 comparand slot", peek_cmp, m_cmp[i]);
    end
    chk("R6 queue drained", 144'(q.size()), 144'(0));
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule